// File: doc/BRIEF.md
# Event Counter with Shared Prescaler

This block is an 8-bit free-running counter with a configuration word. Each step comes either from an instruction-cycle enable or from edges on an external count pin, and the active edge of the pin can be chosen. A divider with a power-of-two ratio sits between the chosen source and the counter. The configuration may instead give that divider to a watchdog elsewhere in the chip. In that case the counter steps on every source event and ignores the ratio field.

When the counter wraps from all ones to zero it raises an interrupt request. The request stays high until it is acknowledged, and a mask bit can stop it from being raised at all. Software can write the counter through a load port. To get a periodic interrupt, software loads the two's complement of the period each time it services the request.

The configuration input `cfg_i` is 7 bits wide:

| Bits | Meaning |
|------|---------|
| [2:0] | ratio code |
| [3] | divider owner: 0 gives the divider to the counter, 1 gives it to the watchdog |
| [4] | pin edge: 0 counts rising edges, 1 counts falling edges |
| [5] | source: 0 counts cycles, 1 counts pin edges |
| [6] | interrupt mask: 1 blocks the request |

Top module: `event_timer`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 and `irq_o` is 0.
- R2: With `cfg_i[5]`=0 and `cfg_i[3]`=1, `count_o` increases by one, modulo 256, in the cycle after each clock edge at which `cyc_en_i` is high, and holds otherwise.
- R3: With `cfg_i[5]`=1, the counter counts transitions of `ext_pin_i` and ignores `cyc_en_i`. `cfg_i[4]`=0 counts rising transitions and 1 counts falling ones. A transition present at clock edge k is reflected in `count_o` after edge k+2, because of the two-flop synchroniser and the edge register.
- R4: With `cfg_i[3]`=0, the counter steps once per 2^(r+1) source events, where r is `cfg_i[2:0]`. Code 0 divides by 2 and code 7 divides by 256. The divider is cleared while the watchdog owns it.
- R5: With `cfg_i[3]`=1, the ratio code has no effect and every source event steps the counter.
- R6: A step from 255 to 0 with `cfg_i[6]`=0 sets `irq_o` at that edge. `irq_o` stays high until a cycle with `irq_ack_i` high.
- R7: With `cfg_i[6]`=1, a wrap does not raise `irq_o`.
- R8: `load_i` high writes `load_val_i` into the counter at the next edge and takes priority over a step there. When `cfg_i[3]`=0, the load also clears the divider, so the count restarts a full ratio from the load.
- R9: With cycle counting, the divider owned by the watchdog and `cyc_en_i` always high, reloading 256-N and acknowledging in the cycle after each request makes the request rise every N+1 cycles.
- R10: When a wrap and `irq_ack_i` fall on the same edge, the request is set and the acknowledge is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle enable, the internal count source |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| cfg_i | input | 7 | Configuration word (bit layout above) |
| load_i | input | 1 | Write `load_val_i` into the counter |
| load_val_i | input | 8 | Value to load |
| irq_ack_i | input | 1 | Clears the pending request |
| count_o | output | 8 | Counter value |
| irq_o | output | 1 | Pending wrap request |

## Verification
The bench checks when a pin transition first shows in the count. A missing or extra synchroniser stage would shift every pin-driven step by a cycle. It runs every ratio code, so an off-by-one divider mask, for example dividing by 1 at code 0, would drift from the reference within a few steps. It checks that a load both wins over a step and restarts the divider: a design that kept the old remainder would step early after the load. It also drives an acknowledge on the very edge of a wrap, where a design that let the acknowledge win would lose an interrupt. It measures the period of the periodic-reload pattern, where a load that failed to take priority over a step would make the period one cycle short.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned RATIO_W = 3;

  typedef struct packed {
    logic               irq_off;
    logic               src_pin;
    logic               fall_edge;
    logic               pre_to_wd;
    logic [RATIO_W-1:0] ratio;
  } tmr_cfg_t;

  localparam int unsigned CFG_W = $bits(tmr_cfg_t);
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sh_q[STAGES-1] is the synchronised pin, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R3
  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R3
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evt_i,
  input  logic            bypass_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ratio_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = 1 << PS_W;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] mask;

  // low ratio+1 bits take part: divide by 2^(ratio+1)
  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i <= int'(ratio_i));
  end

  assign tick_o = bypass_i ? evt_i : (evt_i & (&(pre_q | ~mask)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (bypass_i || clr_i) pre_q <= '0;
    else if (evt_i)             pre_q <= pre_q + 1'b1;
  end

  AST_MIN_DIV_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && !clr_i && tick_o) ##1 (!bypass_i && $stable(ratio_i)) |-> !tick_o); // R4
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             irq_off_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             wrap;

  assign wrap = tick_i & ~load_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // a new wrap outranks an acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                irq_q <= 1'b0;
    else if (wrap && !irq_off_i) irq_q <= 1'b1;
    else if (ack_i)             irq_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q)); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tick_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ack_i) |=> irq_q); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_off_i && !irq_q) |=> !irq_q); // R7
  AST_IRQ_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> ($past(cnt_q) == {CNT_W{1'b1}} && cnt_q == '0)); // R6
endmodule

// File: rtl/event_timer.sv
module event_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_en_i,
  input  logic             ext_pin_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             irq_ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  tmr_cfg_t cfg;
  logic     pin_rise, pin_fall, src_evt, tick;

  assign cfg = tmr_cfg_t'(cfg_i);

  tmr_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign src_evt = cfg.src_pin ? (cfg.fall_edge ? pin_fall : pin_rise) : cyc_en_i;

  tmr_prescaler #(.PS_W(RATIO_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (src_evt),
    .bypass_i (cfg.pre_to_wd),
    .clr_i    (load_i),
    .ratio_i  (cfg.ratio),
    .tick_o   (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .irq_off_i  (cfg.irq_off),
    .ack_i      (irq_ack_i),
    .cnt_o      (count_o),
    .irq_o      (irq_o)
  );
endmodule

// File: tb/event_timer_bench.sv
module event_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, pin = 1'b0, load = 1'b0, ack = 1'b0;
  logic [6:0] cfg = 7'h08;
  logic [7:0] load_val = 8'h00;
  logic [7:0] count;
  logic       irq;

  always #2 clk = ~clk;

  event_timer u_event_timer (
    .clk_i(clk), .rst_ni(rst_n), .cyc_en_i(cyc_en), .ext_pin_i(pin),
    .cfg_i(cfg), .load_i(load), .load_val_i(load_val), .irq_ack_i(ack),
    .count_o(count), .irq_o(irq)
  );

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string req = "R1";

  // behavioural reference
  int m_cnt = 0, m_pre = 0;
  bit m_irq = 0, p1 = 0, p2 = 0, p3 = 0;

  always @(posedge clk) begin
    bit ev, tk, wr;
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_irq = 0; p1 = 0; p2 = 0; p3 = 0;
    end else begin
      if (cfg[5]) ev = cfg[4] ? (!p2 && p3) : (p2 && !p3);
      else        ev = cyc_en;
      tk = 0;
      if (cfg[3]) begin
        m_pre = 0; tk = ev;
      end else if (load) begin
        m_pre = 0;
      end else if (ev) begin
        m_pre = (m_pre + 1) % 256;
        tk = (m_pre % (2 << cfg[2:0])) == 0;
      end
      wr = !load && tk && m_cnt == 255;
      if (load)    m_cnt = load_val;
      else if (tk) m_cnt = (m_cnt + 1) % 256;
      if (wr && !cfg[6]) m_irq = 1;
      else if (ack)      m_irq = 0;
      p3 = p2; p2 = p1; p1 = pin;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (count !== m_cnt[7:0] || irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b", req, count, irq, m_cnt, m_irq);
      end
    end
  end

  task automatic check(string r, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_load(logic [7:0] v);
    load = 1'b1; load_val = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int t_prev;
    repeat (3) @(negedge clk);
    check("R1", count, 0);
    check("R1", irq, 0);
    rst_n = 1'b1;

    // R2: cycle counting, divider owned by the watchdog
    req = "R2"; cfg = 7'b000_1000;
    for (int i = 0; i < 300; i++) begin cyc_en = $urandom_range(0, 1); @(negedge clk); end

    // R3: pin edges, rising then falling, cyc_en noise ignored
    req = "R3";
    for (int e = 0; e < 2; e++) begin
      cfg = {2'b01, e[0], 4'b1000};
      for (int i = 0; i < 200; i++) begin
        cyc_en = $urandom_range(0, 1);
        if ($urandom_range(0, 2) == 0) pin = ~pin;
        @(negedge clk);
      end
    end
    cyc_en = 1'b0; pin = 1'b0;
    repeat (4) @(negedge clk);
    check("R3", count, m_cnt);

    // R4 and R8: every ratio, with a load part way through
    for (int ps = 0; ps < 8; ps++) begin
      req = "R4"; cfg = {4'b0000, ps[2:0]}; cyc_en = 1'b1;
      repeat ((2 << ps) * 2 + 5) @(negedge clk);
      req = "R8"; do_load(8'hFE);
      repeat ((2 << ps) * 3 + 3) @(negedge clk);
    end

    // R5: ratio field ignored when the watchdog owns the divider
    req = "R5"; cfg = 7'b000_1111; do_load(8'h10);
    repeat (6) @(negedge clk);
    check("R5", count, 8'h16);

    // R6: request held until acknowledged
    req = "R6"; cfg = 7'b000_1000; do_load(8'hFD);
    repeat (12) @(negedge clk);
    check("R6", irq, 1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    check("R6", irq, 0);

    // R7: masked wrap
    req = "R7"; cfg = 7'b100_1000; do_load(8'hFD);
    repeat (8) @(negedge clk);
    check("R7", irq, 0);

    // R10: acknowledge on the wrap edge loses
    req = "R10"; cfg = 7'b000_1000; do_load(8'hFF);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    check("R10", irq, 1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;

    // R9: periodic reload of 256-N, N = 20
    req = "R9"; do_load(8'd236);
    t_prev = -1;
    for (int k = 0; k < 5; k++) begin
      while (!irq) @(negedge clk);
      if (t_prev >= 0) check("R9", cyc - t_prev, 21);
      t_prev = cyc;
      load = 1'b1; load_val = 8'd236; ack = 1'b1;
      @(negedge clk);
      load = 1'b0; ack = 1'b0;
    end
    cyc_en = 1'b0;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule